// File: doc/BRIEF.md
# Fetch-Stage Branch Predictor with Selectable Policy

This block guesses, in the same cycle that a fetch address is presented, whether a branch will be taken and where it goes. Configuration inputs choose the policy at run time. One policy always falls through. A static policy takes backward branches and not forward ones. A dynamic policy draws on a direct-mapped cache of recently taken branch targets, on a table of 2-bit saturating direction counters, or on both. A 2-bit record of the most recent resolved outcomes can optionally be XOR-folded into the counter index.

The predict side is purely combinational. It takes the fetch PC, the displacement decoded from the instruction and an is-branch flag. It returns a taken flag and a next-fetch target, which is PC+4 whenever the prediction is not taken. The execute stage drives the update side with a branch's resolved PC, outcome and target. The update trains both structures at the next clock edge, so the prediction changes from the following cycle. A clear input returns the counters to the configured initial state, empties the target cache and zeroes the history. Reset does the same.

Top module: `bp_predictor`

## Requirements
- R1: With pd_is_branch low, pd_taken is 0 and pd_target is pd_pc+4, whatever the mode.
- R2: Mode code 0 (fixed) predicts not taken for every branch, with target pd_pc+4.
- R3: Mode code 1 (static) predicts taken exactly when bit 31 of pd_disp is 1, meaning a negative displacement. The target is then pd_pc+pd_disp; a zero or positive displacement gives not taken with target pd_pc+4.
- R4: Mode code 2 with both cfg_btc_en and cfg_bht_en low, and mode code 3 in any setting, predict not taken with target pd_pc+4.
- R5: Direction counters are 2 bits wide. Each valid update adds 1 on taken and subtracts 1 on not taken, stopping at 3 and at 0. A counter predicts taken when its bit 1 is set. With only the table enabled, a taken prediction targets the cache entry on a hit, or pd_pc+pd_disp on a miss. The table is indexed by PC bits [7:2].
- R6: After reset, and after a cycle with tbl_clear high, every counter reads as cfg_ctr_init, every target-cache entry is empty, and the history is 00. A clear takes priority over an update in the same cycle.
- R7: The target cache has 16 direct-mapped entries, indexed by PC bits [5:2] and tagged with PC bits [31:6]. Only a taken update writes an entry, overwriting whatever was there. A not-taken update leaves the cache unchanged.
- R8: In mode 2 with only the target cache enabled, a branch is predicted taken exactly when it hits, and its target is the stored target.
- R9: In mode 2 with both structures enabled, the counter decides direction. A taken prediction uses the stored target on a hit and pd_pc+pd_disp on a miss.
- R10: The history register shifts in every valid update's outcome at bit 0, with the old bit 0 moving to bit 1. When cfg_ghist_en is high, the history is XORed into bits [1:0] of the table index, both for prediction and for update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Policy: 0 fixed, 1 static, 2 dynamic, 3 not taken |
| cfg_btc_en | input | 1 | Dynamic policy uses the target cache |
| cfg_bht_en | input | 1 | Dynamic policy uses the counter table |
| cfg_ghist_en | input | 1 | Fold history into the table index |
| cfg_ctr_init | input | 2 | Counter value after reset or clear |
| tbl_clear | input | 1 | Reload counters, empty cache, zero history |
| pd_pc | input | 32 | Fetch PC |
| pd_disp | input | 32 | Decoded displacement, two's complement |
| pd_is_branch | input | 1 | Fetched instruction is a conditional branch |
| pd_taken | output | 1 | Predicted taken |
| pd_target | output | 32 | Predicted next fetch address |
| up_valid | input | 1 | Resolved branch present this cycle |
| up_pc | input | 32 | PC of the resolved branch |
| up_taken | input | 1 | Resolved outcome |
| up_target | input | 32 | Resolved taken target |

## Verification
Random predict and update traffic is drawn from a small pool of PCs. Many of these PCs share a cache index but differ in tag, so the traffic separates hits, tag misses and entries overwritten by later taken updates. Runs of the same branch drive counters into both saturation limits, which checks that training stops at 0 and 3 rather than wrapping. The configuration changes at random between steps, so the same table contents are read under each policy and each combination of enables. With history folding on and off, the traffic shows whether the history is XORed into the index at both prediction and update. Directed steps cover the state after reset and after a clear, including under different initial counter values, and check that a not-taken update does not allocate a cache entry.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    PM_FIXED   = 2'd0,
    PM_STATIC  = 2'd1,
    PM_DYNAMIC = 2'd2,
    PM_RSVD    = 2'd3
  } pmode_e;

  // saturating step of a 2-bit direction counter
  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic up);
    logic [1:0] nxt;
    if (up) nxt = (cur == 2'd3) ? cur : cur + 2'd1;
    else    nxt = (cur == 2'd0) ? cur : cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/bp_bht.sv
module bp_bht #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [1:0]       init_ctr,
  input  logic             gh_en,
  input  logic [PC_W-1:0]  rd_pc,
  output logic [1:0]       rd_ctr,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic             upd_taken,
  output logic [1:0]       ghist
);
  import bp_pkg::*;

  localparam int N = 1 << IDX_W;

  logic [1:0]       ctr_q [N];
  logic [1:0]       ctr_d [N];
  logic [N-1:0]     vld_q, vld_d;
  logic [1:0]       gh_q, gh_d;
  logic             tbl_we;
  logic [IDX_W-1:0] gh_mix, rd_idx, up_idx;
  logic [1:0]       up_base;

  // history folded into low index bits when enabled
  assign gh_mix = gh_en ? IDX_W'(gh_q) : '0;
  assign rd_idx = rd_pc[2 +: IDX_W] ^ gh_mix;
  assign up_idx = upd_pc[2 +: IDX_W] ^ gh_mix;

  // an entry never written since reset/clear reads as the configured init
  assign rd_ctr  = vld_q[rd_idx] ? ctr_q[rd_idx] : init_ctr;
  assign up_base = vld_q[up_idx] ? ctr_q[up_idx] : init_ctr;
  assign tbl_we  = upd_valid & ~clr;
  assign ghist   = gh_q;

  always_comb begin
    ctr_d = ctr_q;
    vld_d = vld_q;
    gh_d  = gh_q;
    if (clr) begin
      vld_d = '0;
      gh_d  = 2'b00;
    end else if (tbl_we) begin
      ctr_d[up_idx] = ctr_step(up_base, upd_taken);
      vld_d[up_idx] = 1'b1;
      gh_d          = {gh_q[0], upd_taken};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      gh_q  <= 2'b00;
      for (int i = 0; i < N; i++) ctr_q[i] <= 2'b00;
    end else begin
      vld_q <= vld_d;
      gh_q  <= gh_d;
      for (int i = 0; i < N; i++) ctr_q[i] <= ctr_d[i];
    end
  end

endmodule

// File: rtl/bp_btc.sv
module bp_btc #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [PC_W-1:0] rd_pc,
  output logic            hit,
  output logic [PC_W-1:0] hit_target,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);

  localparam int N     = 1 << IDX_W;
  localparam int TAG_W = PC_W - 2 - IDX_W;

  logic [N-1:0]     vld_q, vld_d;
  logic [TAG_W-1:0] tag_q [N];
  logic [PC_W-1:0]  tgt_q [N];
  logic [IDX_W-1:0] rd_idx, up_idx;
  logic [TAG_W-1:0] rd_tag, up_tag;
  logic             ent_we;

  assign rd_idx = rd_pc[2 +: IDX_W];
  assign rd_tag = rd_pc[PC_W-1 -: TAG_W];
  assign up_idx = upd_pc[2 +: IDX_W];
  assign up_tag = upd_pc[PC_W-1 -: TAG_W];

  assign hit        = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign hit_target = tgt_q[rd_idx];

  // allocation only for taken outcomes
  assign ent_we = upd_valid & upd_taken & ~clr;

  always_comb begin
    vld_d = vld_q;
    if (clr)         vld_d = '0;
    else if (ent_we) vld_d[up_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tag_q[g] <= '0;
          tgt_q[g] <= '0;
        end else if (ent_we && (up_idx == IDX_W'(g))) begin
          tag_q[g] <= up_tag;
          tgt_q[g] <= upd_target;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/bp_policy.sv
module bp_policy #(
  parameter int PC_W = 32
) (
  input  logic [1:0]      mode,
  input  logic            use_btc,
  input  logic            use_bht,
  input  logic            is_branch,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] disp,
  input  logic [1:0]      ctr,
  input  logic            btc_hit,
  input  logic [PC_W-1:0] btc_tgt,
  output logic            taken,
  output logic [PC_W-1:0] target
);
  import bp_pkg::*;

  logic [PC_W-1:0] fall_thru, disp_tgt;
  logic            tk;
  logic [PC_W-1:0] tk_tgt;

  assign fall_thru = pc + PC_W'(4);
  assign disp_tgt  = pc + disp;

  always_comb begin
    tk     = 1'b0;
    tk_tgt = disp_tgt;
    unique case (pmode_e'(mode))
      PM_STATIC: begin
        tk     = disp[PC_W-1];
        tk_tgt = disp_tgt;
      end
      PM_DYNAMIC: begin
        if (use_bht) begin
          tk     = ctr[1];
          tk_tgt = btc_hit ? btc_tgt : disp_tgt;
        end else if (use_btc) begin
          tk     = btc_hit;
          tk_tgt = btc_tgt;
        end
      end
      default: tk = 1'b0;
    endcase
    taken  = is_branch & tk;
    target = taken ? tk_tgt : fall_thru;
  end

endmodule

// File: rtl/bp_predictor.sv
module bp_predictor #(
  parameter int PC_W      = 32,
  parameter int BHT_IDX_W = 6,
  parameter int BTC_IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_mode,
  input  logic            cfg_btc_en,
  input  logic            cfg_bht_en,
  input  logic            cfg_ghist_en,
  input  logic [1:0]      cfg_ctr_init,
  input  logic            tbl_clear,
  input  logic [PC_W-1:0] pd_pc,
  input  logic [PC_W-1:0] pd_disp,
  input  logic            pd_is_branch,
  output logic            pd_taken,
  output logic [PC_W-1:0] pd_target,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic [PC_W-1:0] up_target
);

  logic [1:0]      rd_ctr;
  logic [1:0]      ghist_q;
  logic            btc_hit;
  logic [PC_W-1:0] btc_tgt;

  bp_bht #(.PC_W(PC_W), .IDX_W(BHT_IDX_W)) u_bht (
    .clk(clk), .rst_n(rst_n), .clr(tbl_clear), .init_ctr(cfg_ctr_init),
    .gh_en(cfg_ghist_en), .rd_pc(pd_pc), .rd_ctr(rd_ctr),
    .upd_valid(up_valid), .upd_pc(up_pc), .upd_taken(up_taken),
    .ghist(ghist_q)
  );

  bp_btc #(.PC_W(PC_W), .IDX_W(BTC_IDX_W)) u_btc (
    .clk(clk), .rst_n(rst_n), .clr(tbl_clear), .rd_pc(pd_pc),
    .hit(btc_hit), .hit_target(btc_tgt),
    .upd_valid(up_valid), .upd_pc(up_pc), .upd_taken(up_taken),
    .upd_target(up_target)
  );

  bp_policy #(.PC_W(PC_W)) u_pol (
    .mode(cfg_mode), .use_btc(cfg_btc_en), .use_bht(cfg_bht_en),
    .is_branch(pd_is_branch), .pc(pd_pc), .disp(pd_disp), .ctr(rd_ctr),
    .btc_hit(btc_hit), .btc_tgt(btc_tgt),
    .taken(pd_taken), .target(pd_target)
  );

endmodule

// File: rtl/bp_predictor_chk.sv
module bp_predictor_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      cfg_mode,
  input logic            cfg_btc_en,
  input logic            cfg_bht_en,
  input logic            tbl_clear,
  input logic [PC_W-1:0] pd_pc,
  input logic [PC_W-1:0] pd_disp,
  input logic            pd_is_branch,
  input logic            pd_taken,
  input logic [PC_W-1:0] pd_target,
  input logic            up_valid,
  input logic            up_taken,
  input logic [1:0]      ghist_q
);

  AST_NOBR_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_is_branch |-> (!pd_taken && pd_target == pd_pc + PC_W'(4))); // R1

  AST_FIXED_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd0) |-> !pd_taken); // R2

  AST_STATIC_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd1 && pd_is_branch) |-> (pd_taken == pd_disp[PC_W-1])); // R3

  AST_NO_STRUCT_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_mode == 2'd2 && !cfg_btc_en && !cfg_bht_en) || cfg_mode == 2'd3) |-> !pd_taken); // R4

  AST_GHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !tbl_clear) |=> (ghist_q[0] == $past(up_taken))); // R10

  AST_CLEAR_HIST: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_clear |=> (ghist_q == 2'b00)); // R6

endmodule

bind bp_predictor bp_predictor_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/sim_bp_predictor.sv
module sim_bp_predictor;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_mode;
  logic        cfg_btc_en, cfg_bht_en, cfg_ghist_en;
  logic [1:0]  cfg_ctr_init;
  logic        tbl_clear;
  logic [31:0] pd_pc, pd_disp;
  logic        pd_is_branch;
  logic        pd_taken;
  logic [31:0] pd_target;
  logic        up_valid;
  logic [31:0] up_pc;
  logic        up_taken;
  logic [31:0] up_target;

  always #10 clk = ~clk; // 50 MHz

  bp_predictor u0 (.*);

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference state
  logic [1:0]  m_ctr [64];
  logic        m_bv  [16];
  logic [25:0] m_btag [16];
  logic [31:0] m_btgt [16];
  logic [1:0]  m_gh;

  task automatic model_clear(input logic [1:0] init);
    for (int i = 0; i < 64; i++) m_ctr[i] = init;
    for (int i = 0; i < 16; i++) m_bv[i] = 1'b0;
    m_gh = 2'b00;
  endtask

  function automatic logic [5:0] m_bidx(input logic [31:0] pc, input logic ge);
    return pc[7:2] ^ (ge ? {4'b0, m_gh} : 6'b0);
  endfunction

  function automatic logic [32:0] m_predict(input logic [1:0] m, input logic be,
      input logic he, input logic ge, input logic [31:0] pc, input logic [31:0] d,
      input logic br);
    logic tk;
    logic [31:0] tg;
    logic hit;
    logic [3:0] ci;
    tk = 1'b0;
    tg = pc + d;
    ci = pc[5:2];
    hit = m_bv[ci] && (m_btag[ci] == pc[31:6]);
    if (br) begin
      if (m == 2'd1) tk = d[31];
      else if (m == 2'd2) begin
        if (he) begin
          tk = m_ctr[m_bidx(pc, ge)][1];
          if (hit) tg = m_btgt[ci];
        end else if (be) begin
          tk = hit;
          tg = m_btgt[ci];
        end
      end
    end
    if (!tk) tg = pc + 32'd4;
    return {tk, tg};
  endfunction

  task automatic model_update(input logic ge, input logic [31:0] pc, input logic t,
      input logic [31:0] tgt);
    logic [5:0] bi;
    bi = m_bidx(pc, ge);
    if (t) m_ctr[bi] = (m_ctr[bi] == 2'd3) ? 2'd3 : m_ctr[bi] + 2'd1;
    else   m_ctr[bi] = (m_ctr[bi] == 2'd0) ? 2'd0 : m_ctr[bi] - 2'd1;
    if (t) begin
      m_bv[pc[5:2]]   = 1'b1;
      m_btag[pc[5:2]] = pc[31:6];
      m_btgt[pc[5:2]] = tgt;
    end
    m_gh = {m_gh[0], t};
  endtask

  function automatic string auto_tag(input logic [1:0] m, input logic be,
      input logic he, input logic ge, input logic br);
    if (!br) return "R1";
    if (m == 2'd0) return "R2";
    if (m == 2'd1) return "R3";
    if (m == 2'd3 || (!be && !he)) return "R4";
    if (he && ge) return "R10";
    if (he && be) return "R9";
    if (he) return "R5";
    return "R8";
  endfunction

  // one cycle: apply config, predict inputs and optional update; check prediction
  task automatic step(input logic [1:0] m, input logic be, input logic he,
      input logic ge, input logic [31:0] pc, input logic [31:0] d, input logic br,
      input logic uv, input logic [31:0] upc, input logic ut, input logic [31:0] utg,
      input string tag);
    logic [32:0] exp;
    string t;
    @(negedge clk);
    cfg_mode = m; cfg_btc_en = be; cfg_bht_en = he; cfg_ghist_en = ge;
    pd_pc = pc; pd_disp = d; pd_is_branch = br;
    up_valid = uv; up_pc = upc; up_taken = ut; up_target = utg;
    #1;
    exp = m_predict(m, be, he, ge, pc, d, br);
    t = (tag.len() != 0) ? tag : auto_tag(m, be, he, ge, br);
    total++;
    if ({pd_taken, pd_target} !== exp) begin
      bad++;
      $display("FAIL %s: pc=%h taken=%0b target=%h expected taken=%0b target=%h",
               t, pc, pd_taken, pd_target, exp[32], exp[31:0]);
    end
    if (uv) model_update(ge, upc, ut, utg);
  endtask

  task automatic do_clear(input logic [1:0] init);
    @(negedge clk);
    up_valid = 1'b0;
    cfg_ctr_init = init;
    tbl_clear = 1'b1;
    @(negedge clk);
    tbl_clear = 1'b0;
    model_clear(init);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  localparam logic [31:0] PA = 32'h0000_0100;
  localparam logic [31:0] PB = 32'h0000_0210;
  localparam logic [31:0] PC_ALIAS = 32'h0000_0410; // same cache index as PB

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(1234);
    rst_n = 1'b0;
    cfg_mode = 2'd2; cfg_btc_en = 1'b0; cfg_bht_en = 1'b1; cfg_ghist_en = 1'b0;
    cfg_ctr_init = 2'd2; tbl_clear = 1'b0;
    pd_pc = '0; pd_disp = '0; pd_is_branch = 1'b0;
    up_valid = 1'b0; up_pc = '0; up_taken = 1'b0; up_target = '0;
    model_clear(2'd2);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state: counters at init (2 -> taken), cache empty
    step(2, 0, 1, 0, PA, 32'h40, 1, 0, 0, 0, 0, "R6");
    step(2, 1, 0, 0, PA, 32'h40, 1, 0, 0, 0, 0, "R6");
    step(2, 1, 1, 0, PA, 32'h40, 0, 0, 0, 0, 0, "R1");

    // fixed, static, disabled structures
    step(0, 1, 1, 0, PA, 32'hFFFF_FFF0, 1, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, PA, 32'hFFFF_FFF0, 1, 0, 0, 0, 0, "R3");
    step(1, 0, 0, 0, PA, 32'h0, 1, 0, 0, 0, 0, "R3");
    step(1, 0, 0, 0, PA, 32'h20, 1, 0, 0, 0, 0, "R3");
    step(2, 0, 0, 0, PA, 32'hFFFF_FFF0, 1, 0, 0, 0, 0, "R4");
    step(3, 1, 1, 0, PA, 32'hFFFF_FFF0, 1, 0, 0, 0, 0, "R4");

    // saturation at 3 then at 0
    do_clear(2'd3);
    for (int i = 0; i < 3; i++) step(2, 0, 1, 0, PA, 32'h40, 1, 1, PA, 1, 32'h500, "R5");
    for (int i = 0; i < 5; i++) step(2, 0, 1, 0, PA, 32'h40, 1, 1, PA, 0, 0, "R5");
    step(2, 0, 1, 0, PA, 32'h40, 1, 1, PA, 1, 32'h500, "R5");
    step(2, 0, 1, 0, PA, 32'h40, 1, 0, 0, 0, 0, "R5");

    // target cache allocation rules
    do_clear(2'd0);
    step(2, 1, 0, 0, PB, 32'h80, 1, 1, PB, 0, 32'h999, "R7");
    step(2, 1, 0, 0, PB, 32'h80, 1, 1, PB, 1, 32'h1234, "R7");
    step(2, 1, 0, 0, PB, 32'h80, 1, 0, 0, 0, 0, "R7");
    step(2, 1, 0, 0, PC_ALIAS, 32'h80, 1, 1, PC_ALIAS, 1, 32'h5678, "R7");
    step(2, 1, 0, 0, PB, 32'h80, 1, 0, 0, 0, 0, "R7");
    step(2, 1, 1, 0, PC_ALIAS, 32'h80, 1, 0, 0, 0, 0, "R9");

    // history folding
    do_clear(2'd1);
    for (int i = 0; i < 6; i++)
      step(2, 0, 1, 1, PA, 32'h40, 1, 1, PA, (i % 3) != 0, 32'h700, "R10");

    // clear empties cache and resets counters
    do_clear(2'd1);
    step(2, 1, 0, 0, PC_ALIAS, 32'h80, 1, 0, 0, 0, 0, "R6");
    step(2, 0, 1, 0, PA, 32'h40, 1, 0, 0, 0, 0, "R6");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [1:0]  m;
      logic [31:0] pc, upc, d;
      m = ($urandom_range(0, 9) < 7) ? 2'd2 : 2'($urandom_range(0, 3));
      pc  = (32'($urandom_range(0, 3)) << 10) | (32'($urandom_range(0, 15)) << 2);
      upc = (32'($urandom_range(0, 3)) << 10) | (32'($urandom_range(0, 15)) << 2);
      d = $urandom_range(0, 1) ? -(32'($urandom_range(1, 64)) << 2)
                               : (32'($urandom_range(0, 64)) << 2);
      if ($urandom_range(0, 299) == 0) do_clear(2'($urandom_range(0, 3)));
      step(m, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), pc, d, ($urandom_range(0, 7) != 0),
           1'($urandom_range(0, 1)), upc, 1'($urandom_range(0, 1)),
           $urandom & 32'hFFFF_FFFC, "");
    end

    finish_run();
  end

endmodule